// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the front end of a legacy configuration space reached through a pair of 8-bit I/O ports: an index port at a base address and a data port at base+1. Software picks a register by writing its number to the index port, then reads or writes the data port. The base is one of two fixed addresses, 0x2E or 0x4E, chosen by a strap input.

The space is guarded by a key lock. It opens only after two back-to-back writes of 0x87 to the index port, and a write of 0xAA to the index port closes it again. While it is closed, the data port reads as 0xFF and ignores writes. Once it is open, indices below 0x30 reach registers shared by every logical device: the device-select register at 0x07, a read-only chip identifier at 0x20/0x21, and a bank of read/write global option registers from 0x22 to 0x2F. Indices at 0x30 and above are passed to an internal banked-register interface, tagged with the logical-device number, so that per-device logic can answer them.

Top module: `sio_cfg_port`

## Requirements
- R1: Only the two addresses base (index port) and base+1 (data port) are decoded. base is 0x2E when base_sel_i is 0 and 0x4E when it is 1. Accesses at any other address change no state, and reads there return 0xFF.
- R2: The space opens only after two consecutive index-port writes of 0x87. Any other value written to the index port while it is closed cancels the progress, so the next 0x87 counts as the first again. Data-port accesses do not affect progress.
- R3: While the space is closed, data-port and index-port reads return 0xFF, and data-port writes change no register and produce no banked access.
- R4: An index-port write of 0xAA while the space is open closes it. Any other index-port write while open loads the index register, and an index-port read while open returns the index register.
- R5: Indices 0x20 and 0x21 read as the high and low bytes of the CHIP_ID parameter (default 0xA231: the top 12 bits are 0xA23 and the low nibble is the revision). Writes to them are discarded.
- R6: Indices GLB_FIRST to GLB_LAST (default 0x22 to 0x2F) are independent 8-bit read/write registers that reset to 0x00. Other indices below 0x30, except 0x07 and 0x20/0x21, read as 0x00 and ignore writes.
- R7: Index 0x07 is a read/write logical-device register.
- R8: An open data-port access at an index of 0x30 or above drives bank_wr_o or bank_rd_o for that cycle, with bank_dev_o set to the logical-device register, bank_idx_o set to the index and bank_wdata_o set to the written byte. A read returns bank_rdata_i in the same cycle.
- R9: After reset the space is closed, the logical-device register is 0x00 and the global registers are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_sel_i | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr_i | input | ADDR_W | I/O address of the current access |
| io_wr_i | input | 1 | Write strobe, one cycle per write |
| io_rd_i | input | 1 | Read strobe, one cycle per read |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid in the cycle of io_rd_i |
| bank_wr_o | output | 1 | Banked register write strobe |
| bank_rd_o | output | 1 | Banked register read strobe |
| bank_dev_o | output | 8 | Logical device of the banked access |
| bank_idx_o | output | 8 | Register index of the banked access |
| bank_wdata_o | output | 8 | Banked write data |
| bank_rdata_i | input | 8 | Banked read data, returned in the same cycle |

## Verification
The bench targets the key sequence: an interrupted 0x87 pair must not open the space, because a design that remembered only the last 0x87 would open early. It checks that a data write made while the space is closed leaves a global register untouched and produces no banked strobe, and that writes to the chip identifier are discarded, since a design without those guards would corrupt state. Base switching is exercised so that a design which hard-wired one base, or decoded too many addresses, would answer at the wrong port. Banked accesses are compared against the device number just written, so a design that took a stale device number or used the wrong index threshold would show up.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_ARMED  = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [BYTE_W-1:0] KEY_ENTER  = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_EXIT   = 8'hAA;
  localparam logic [BYTE_W-1:0] IDX_LDN    = 8'h07;
  localparam logic [BYTE_W-1:0] IDX_ID_HI  = 8'h20;
  localparam logic [BYTE_W-1:0] IDX_ID_LO  = 8'h21;
  localparam logic [BYTE_W-1:0] IDX_BANKED = 8'h30;
  localparam logic [BYTE_W-1:0] IDLE_BYTE  = 8'hFF;
endpackage

// File: rtl/sio_key_lock.sv
`timescale 1ns/1ps
module sio_key_lock
  import sio_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [BYTE_W-1:0] key_i,
  output logic              open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_wr_i) begin
      unique case (state_q)
        KEY_LOCKED: state_d = (key_i == KEY_ENTER) ? KEY_ARMED : KEY_LOCKED;
        KEY_ARMED:  state_d = (key_i == KEY_ENTER) ? KEY_OPEN  : KEY_LOCKED;
        KEY_OPEN:   state_d = (key_i == KEY_EXIT)  ? KEY_LOCKED : KEY_OPEN;
        default:    state_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KEY_OPEN);
endmodule

// File: rtl/sio_global_file.sv
`timescale 1ns/1ps
module sio_global_file
  import sio_cfg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FIRST = 8'h22,
  parameter logic [BYTE_W-1:0] LAST  = 8'h2F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int NUM = int'(LAST) - int'(FIRST) + 1;

  logic [NUM-1:0]             sel;
  logic [NUM-1:0][BYTE_W-1:0] regs_q;

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] MY_IDX = BYTE_W'(int'(FIRST) + g);
    assign sel[g] = (idx_i == MY_IDX);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             regs_q[g] <= '0;
      else if (wr_i && sel[g]) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (sel[i]) rdata_o = regs_q[i];
    end
  end

  assign hit_o = |sel;
endmodule

// File: rtl/sio_bank_route.sv
`timescale 1ns/1ps
module sio_bank_route
  import sio_cfg_pkg::*;
(
  input  logic              acc_wr_i,
  input  logic              acc_rd_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] ldn_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] bank_rdata_i,
  output logic              hit_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              bank_wr_o,
  output logic              bank_rd_o,
  output logic [BYTE_W-1:0] bank_dev_o,
  output logic [BYTE_W-1:0] bank_idx_o,
  output logic [BYTE_W-1:0] bank_wdata_o
);
  assign hit_o        = (idx_i >= IDX_BANKED);
  assign bank_wr_o    = acc_wr_i && hit_o;
  assign bank_rd_o    = acc_rd_i && hit_o;
  assign bank_dev_o   = ldn_i;
  assign bank_idx_o   = idx_i;
  assign bank_wdata_o = wdata_i;
  assign rdata_o      = bank_rdata_i;
endmodule

// File: rtl/sio_cfg_port.sv
`timescale 1ns/1ps
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_LO   = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] BASE_HI   = ADDR_W'(16'h004E),
  parameter logic [15:0]       CHIP_ID   = 16'hA231,
  parameter logic [7:0]        GLB_FIRST = 8'h22,
  parameter logic [7:0]        GLB_LAST  = 8'h2F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_sel_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              bank_wr_o,
  output logic              bank_rd_o,
  output logic [7:0]        bank_dev_o,
  output logic [7:0]        bank_idx_o,
  output logic [7:0]        bank_wdata_o,
  input  logic [7:0]        bank_rdata_i
);
  logic [ADDR_W-1:0] base;
  logic              idx_port, dat_port;
  logic              idx_wr, dat_wr, dat_rd;
  logic              cfg_open;
  logic [7:0]        index_q, ldn_q;
  logic              glb_hit, bank_hit;
  logic [7:0]        glb_rdata, bank_rd_data;
  logic [7:0]        cfg_rdata;

  assign base     = base_sel_i ? BASE_HI : BASE_LO;
  assign idx_port = (io_addr_i == base);
  assign dat_port = (io_addr_i == base + ADDR_W'(1));
  assign idx_wr   = io_wr_i && idx_port;
  assign dat_wr   = io_wr_i && dat_port && cfg_open;
  assign dat_rd   = io_rd_i && dat_port && cfg_open;

  sio_key_lock u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (idx_wr),
    .key_i    (io_wdata_i),
    .open_o   (cfg_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr && cfg_open && io_wdata_i != KEY_EXIT) index_q <= io_wdata_i;
      if (dat_wr && index_q == IDX_LDN) ldn_q <= io_wdata_i;
    end
  end

  sio_global_file #(
    .FIRST (GLB_FIRST),
    .LAST  (GLB_LAST)
  ) u_glb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (dat_wr),
    .idx_i   (index_q),
    .wdata_i (io_wdata_i),
    .hit_o   (glb_hit),
    .rdata_o (glb_rdata)
  );

  sio_bank_route u_bank (
    .acc_wr_i     (dat_wr),
    .acc_rd_i     (dat_rd),
    .idx_i        (index_q),
    .ldn_i        (ldn_q),
    .wdata_i      (io_wdata_i),
    .bank_rdata_i (bank_rdata_i),
    .hit_o        (bank_hit),
    .rdata_o      (bank_rd_data),
    .bank_wr_o    (bank_wr_o),
    .bank_rd_o    (bank_rd_o),
    .bank_dev_o   (bank_dev_o),
    .bank_idx_o   (bank_idx_o),
    .bank_wdata_o (bank_wdata_o)
  );

  always_comb begin
    if (bank_hit)                    cfg_rdata = bank_rd_data;
    else if (index_q == IDX_LDN)     cfg_rdata = ldn_q;
    else if (index_q == IDX_ID_HI)   cfg_rdata = CHIP_ID[15:8];
    else if (index_q == IDX_ID_LO)   cfg_rdata = CHIP_ID[7:0];
    else if (glb_hit)                cfg_rdata = glb_rdata;
    else                             cfg_rdata = 8'h00;
  end

  always_comb begin
    if (dat_rd)                                 io_rdata_o = cfg_rdata;
    else if (io_rd_i && idx_port && cfg_open)   io_rdata_o = index_q;
    else                                        io_rdata_o = IDLE_BYTE;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
`timescale 1ns/1ps
module sio_cfg_port_chk #(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_LO = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] BASE_HI = ADDR_W'(16'h004E)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              base_sel_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_wr_i,
  input logic              io_rd_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o,
  input logic              bank_wr_o,
  input logic              bank_rd_o,
  input logic [7:0]        bank_idx_o,
  input logic              cfg_open,
  input logic [7:0]        ldn_q,
  input logic [7:0]        index_q
);
  logic [ADDR_W-1:0] c_base;
  logic              c_idx, c_dat;
  assign c_base = base_sel_i ? BASE_HI : BASE_LO;
  assign c_idx  = (io_addr_i == c_base);
  assign c_dat  = (io_addr_i == c_base + ADDR_W'(1));

  a_r2_open_after_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_open) |-> $past(io_wr_i && c_idx && io_wdata_i == 8'h87));

  a_r4_exit_key_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open && io_wr_i && c_idx && io_wdata_i == 8'hAA) |=> !cfg_open);

  a_r3_locked_reads_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open && io_rd_i) |-> io_rdata_o == 8'hFF);

  a_r8_bank_only_open_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_wr_o || bank_rd_o) |-> (cfg_open && c_dat && bank_idx_o >= 8'h30));

  a_r7_ldn_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && c_dat && cfg_open && index_q == 8'h07) |=> $stable(ldn_q));

  a_r1_off_port_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rd_i && !c_idx && !c_dat) |-> io_rdata_o == 8'hFF);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W  (ADDR_W),
  .BASE_LO (BASE_LO),
  .BASE_HI (BASE_HI)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .base_sel_i (base_sel_i),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .bank_wr_o  (bank_wr_o),
  .bank_rd_o  (bank_rd_o),
  .bank_idx_o (bank_idx_o),
  .cfg_open   (cfg_open),
  .ldn_q      (ldn_q),
  .index_q    (index_q)
);

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
module tb_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_sel_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0;
  logic        io_rd_i = 1'b0;
  logic [7:0]  io_wdata_i = '0;
  logic [7:0]  io_rdata_o;
  logic        bank_wr_o, bank_rd_o;
  logic [7:0]  bank_dev_o, bank_idx_o, bank_wdata_o, bank_rdata_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_rd_q[$];
  string      tag_rd_q[$];
  logic [23:0] exp_bw_q[$];

  always #2.5 clk = ~clk;

  // bench model of a banked device: data derived from device and index
  assign bank_rdata_i = bank_dev_o ^ bank_idx_o ^ 8'h5A;

  sio_cfg_port dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .base_sel_i   (base_sel_i),
    .io_addr_i    (io_addr_i),
    .io_wr_i      (io_wr_i),
    .io_rd_i      (io_rd_i),
    .io_wdata_i   (io_wdata_i),
    .io_rdata_o   (io_rdata_o),
    .bank_wr_o    (bank_wr_o),
    .bank_rd_o    (bank_rd_o),
    .bank_dev_o   (bank_dev_o),
    .bank_idx_o   (bank_idx_o),
    .bank_wdata_o (bank_wdata_o),
    .bank_rdata_i (bank_rdata_i)
  );

  task automatic iow(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk);
    io_wr_i = 1'b0;
  endtask

  task automatic ior(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_rd_q.push_back(exp);
    tag_rd_q.push_back(tag);
    @(negedge clk);
    io_addr_i = a; io_rd_i = 1'b1;
    @(negedge clk);
    io_rd_i = 1'b0;
  endtask

  task automatic expect_bank_wr(input logic [7:0] dev, input logic [7:0] idx, input logic [7:0] d);
    exp_bw_q.push_back({dev, idx, d});
  endtask

  // monitor: samples 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_ni && io_rd_i) begin
        logic [7:0] e;
        string t;
        e = exp_rd_q.pop_front();
        t = tag_rd_q.pop_front();
        checks++;
        if (io_rdata_o !== e) begin
          fails++;
          $display("FAIL %s: read got %02h expected %02h", t, io_rdata_o, e);
        end
      end
      if (rst_ni && bank_wr_o) begin
        checks++;
        if (exp_bw_q.size() == 0) begin
          fails++;
          $display("FAIL R8/R3: unexpected bank write got %02h/%02h/%02h expected none",
                   bank_dev_o, bank_idx_o, bank_wdata_o);
        end else begin
          logic [23:0] eb;
          eb = exp_bw_q.pop_front();
          if ({bank_dev_o, bank_idx_o, bank_wdata_o} !== eb) begin
            fails++;
            $display("FAIL R8: bank write got %06h expected %06h",
                     {bank_dev_o, bank_idx_o, bank_wdata_o}, eb);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finish_run();
  end

  localparam logic [15:0] IX = 16'h002E, DT = 16'h002F;
  localparam logic [15:0] IX2 = 16'h004E, DT2 = 16'h004F;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R9 / R3: reset state is locked
    ior(DT, 8'hFF, "R9 locked data read after reset");
    ior(IX, 8'hFF, "R3 locked index read");

    // R2: interrupted key sequence must not open
    iow(IX, 8'h87); iow(IX, 8'h12); iow(IX, 8'h87);
    ior(DT, 8'hFF, "R2 interrupted key keeps lock");
    iow(IX, 8'h87);
    // open now; R9 ldn reset, R4 index readback
    iow(IX, 8'h07);
    ior(IX, 8'h07, "R4 index readback");
    ior(DT, 8'h00, "R9 ldn resets to zero");

    // R6 globals
    iow(IX, 8'h22); iow(DT, 8'h5A);
    iow(IX, 8'h2F); iow(DT, 8'hC3);
    ior(DT, 8'hC3, "R6 global 0x2F");
    iow(IX, 8'h22);
    ior(DT, 8'h5A, "R6 global 0x22");
    iow(IX, 8'h10); iow(DT, 8'h99);
    ior(DT, 8'h00, "R6 reserved index reads zero");

    // R5 chip id, writes dropped
    iow(IX, 8'h20); iow(DT, 8'h00);
    ior(DT, 8'hA2, "R5 chip id high");
    iow(IX, 8'h21); iow(DT, 8'hFF);
    ior(DT, 8'h31, "R5 chip id low");

    // R7 ldn, R8 banked
    iow(IX, 8'h07); iow(DT, 8'h05);
    ior(DT, 8'h05, "R7 ldn readback");
    iow(IX, 8'h30);
    expect_bank_wr(8'h05, 8'h30, 8'h77);
    iow(DT, 8'h77);
    iow(IX, 8'hE1);
    ior(DT, 8'h05 ^ 8'hE1 ^ 8'h5A, "R8 banked read");
    iow(IX, 8'h2F);
    ior(DT, 8'hC3, "R8 index 0x2F stays global");

    // R4 exit key, R3 locked writes ignored
    iow(IX, 8'h22);
    iow(IX, 8'hAA);
    ior(DT, 8'hFF, "R4 exit key locks");
    iow(DT, 8'h33);
    iow(IX, 8'h87); iow(IX, 8'h87);
    ior(IX, 8'h22, "R4 index kept across lock");
    ior(DT, 8'h5A, "R3 locked write ignored");
    iow(IX, 8'hAA);
    iow(IX, 8'h40); iow(DT, 8'h11); // locked, no bank write expected (R3)
    iow(IX, 8'h87); iow(IX, 8'h87);
    iow(IX, 8'h40);
    ior(DT, 8'h05 ^ 8'h40 ^ 8'h5A, "R3 locked bank write suppressed");

    // R1 base select
    base_sel_i = 1'b1;
    ior(DT, 8'hFF, "R1 old base not decoded");
    iow(IX2, 8'h2F);
    ior(DT2, 8'hC3, "R1 alternate base data port");
    ior(IX2, 8'h2F, "R1 alternate base index port");
    iow(16'h0080, 8'hAA);
    ior(DT2, 8'hC3, "R1 off-port write ignored");
    ior(16'h0081, 8'hFF, "R1 off-port read idle");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_bw_q.size() != 0) begin
      fails++;
      $display("FAIL R8: missing bank writes got %0d pending expected 0", exp_bw_q.size());
    end
    finish_run();
  end
endmodule